// File: doc/BRIEF.md
# Printer Port Register Emulator

This block presents a byte-wide register window to a host bus and behaves like a standard printer port. Software can write a data byte and drive the control lines. It can poll a status byte and read the data back. No printer is attached: the block acknowledges each character by itself. A write that raises the strobe line with the port selected and out of initialise sends the latched data byte to a downstream printer model. The byte appears there as a single-cycle valid pulse. Software that polls the status register after a strobe sees busy and acknowledge move through a believable sequence.

A level interrupt output follows an internal pending flag. The flag is set when the strobe line is pulled low while interrupts are enabled. Any status read clears it. All register updates happen on one clock edge. Read data is a combinational view of the register addressed by the current offset. Only the three low address bits are decoded, so the register window repeats across the whole address range.

Top module: `prn_port_regs`

## Requirements
- R1: Only address bits [2:0] are decoded. Offset 0 is data, 1 is status and 2 is control. A read of offsets 3 to 7 returns 0xFF, and a write to them changes no register. Higher address bits are ignored.
- R2: While reset is active and after it is released, the data latch reads 0xFF, status reads 0xD9, control reads 0xCC, `irq_o` is 0 and `byte_valid_o` is 0.
- R3: A control write stores the written value with bits 7 and 6 forced to 1. A later control read returns that stored value.
- R4: A control write with bit 2 (init) equal to 0 loads status with 0xD8 (busy, ack, online and error set).
- R5: A control write with init=1, select (bit 3)=1 and strobe (bit 0)=1 clears status bit 7 (busy). If the strobe previously stored was 0, the data latch appears on `byte_o` with `byte_valid_o` high for exactly the one cycle after the write. A write that leaves strobe at 1 emits nothing.
- R6: A control write with select=0 neither emits a byte, nor changes status, nor sets the pending flag.
- R7: A control write with init=1, select=1 and strobe=0 sets the pending flag, but only when the previously stored control had bit 4 (interrupt enable) set. `irq_o` goes high from the next cycle and stays high through data writes.
- R8: A status read returns the current status and clears the pending flag, so `irq_o` is low from the next cycle.
- R9: A status read made while status bit 7 is 0 and control strobe is 0 steps the handshake. A set ack (bit 6) is cleared. A clear ack sets both ack and busy. Otherwise the read leaves status unchanged.
- R10: A data read returns the input latch, which holds 0xFF, when control bit 5 (direction) is 1. It returns the output data latch when direction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address; only bits [2:0] are decoded |
| wr_i | input | 1 | Write strobe for one cycle |
| rd_i | input | 1 | Read strobe for one cycle; status side effects happen at the edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Level interrupt, high while the pending flag is set |
| byte_valid_o | output | 1 | One-cycle pulse that marks an emitted byte |
| byte_o | output | 8 | Emitted byte |

## Verification
The assertions assume that the host never raises `wr_i` and `rd_i` in the same cycle, and one property states this. They also assume that each access lasts exactly one cycle. The bench meets both assumptions because a single task drives every access: it raises one strobe for one clock, then lowers it before the next access. A status read is counted as a read only in the cycle in which `rd_i` is high, so a steady `rdata_o` view never steps the handshake.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int DW = 8;
  localparam int OFS_W = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int C_STB = 0;
  localparam int C_SEL = 3;
  localparam int C_INI = 2;
  localparam int C_IEN = 4;
  localparam int C_DIR = 5;

  // status bit positions
  localparam int S_ACK  = 6;
  localparam int S_BUSY = 7;

  localparam logic [DW-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [DW-1:0] CTRL_RST   = 8'hCC;
  localparam logic [DW-1:0] STAT_RST   = 8'hD9;
  localparam logic [DW-1:0] STAT_INIT  = 8'hD8;
  localparam logic [DW-1:0] IDLE_BYTE  = 8'hFF;
endpackage

// File: rtl/prn_decode.sv
module prn_decode
  import prn_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              wr_data_o,
  output logic              wr_ctrl_o,
  output logic              rd_stat_o
);
  assign ofs_o     = addr_i[OFS_W-1:0];
  assign wr_data_o = wr_i && (ofs_o == OFS_DATA);
  assign wr_ctrl_o = wr_i && (ofs_o == OFS_CTRL);
  assign rd_stat_o = rd_i && (ofs_o == OFS_STAT);
endmodule

// File: rtl/prn_ctrl.sv
module prn_ctrl
  import prn_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] ctrl_o,
  output logic          init_load_o,
  output logic          busy_clr_o,
  output logic          int_set_o,
  output logic          byte_valid_o,
  output logic [DW-1:0] byte_o
);
  logic [DW-1:0] ctrl_q, nv;
  logic          act, emit;

  assign nv          = wdata_i | CTRL_FORCE;
  assign init_load_o = wr_ctrl_i && !nv[C_INI];
  assign act         = wr_ctrl_i && nv[C_INI] && nv[C_SEL];
  assign busy_clr_o  = act && nv[C_STB];
  // emit only on a strobe 0->1 transition
  assign emit        = busy_clr_o && !ctrl_q[C_STB];
  // interrupt enable is taken from the control value before the write
  assign int_set_o   = act && !nv[C_STB] && ctrl_q[C_IEN];
  assign ctrl_o      = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q       <= CTRL_RST;
      byte_valid_o <= 1'b0;
      byte_o       <= IDLE_BYTE;
    end else begin
      if (wr_ctrl_i) ctrl_q <= nv;
      byte_valid_o <= emit;
      if (emit) byte_o <= data_i;
    end
  end
endmodule

// File: rtl/prn_status.sv
module prn_status
  import prn_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_load_i,
  input  logic          busy_clr_i,
  input  logic          int_set_i,
  input  logic          rd_stat_i,
  input  logic          ctrl_stb_i,
  output logic [DW-1:0] status_o,
  output logic          pend_o
);
  logic [DW-1:0] st_q;
  logic          pend_q;

  assign status_o = st_q;
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= STAT_RST;
      pend_q <= 1'b0;
    end else begin
      if (init_load_i) begin
        st_q <= STAT_INIT;
      end else if (busy_clr_i) begin
        st_q[S_BUSY] <= 1'b0;
      end else if (rd_stat_i && !st_q[S_BUSY] && !ctrl_stb_i) begin
        // built-in printer handshake stepped by status polling
        if (st_q[S_ACK]) begin
          st_q[S_ACK] <= 1'b0;
        end else begin
          st_q[S_ACK]  <= 1'b1;
          st_q[S_BUSY] <= 1'b1;
        end
      end
      if (int_set_i)      pend_q <= 1'b1;
      else if (rd_stat_i) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic              byte_valid_o,
  output logic [DW-1:0]     byte_o
);
  logic [OFS_W-1:0] ofs;
  logic             wr_data, wr_ctrl, rd_stat;
  logic             init_load, busy_clr, int_set, pend;
  logic [DW-1:0]    data_q, ctrl_q, status_q;

  prn_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .ofs_o     (ofs),
    .wr_data_o (wr_data),
    .wr_ctrl_o (wr_ctrl),
    .rd_stat_o (rd_stat)
  );

  prn_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ctrl_i    (wr_ctrl),
    .wdata_i      (wdata_i),
    .data_i       (data_q),
    .ctrl_o       (ctrl_q),
    .init_load_o  (init_load),
    .busy_clr_o   (busy_clr),
    .int_set_o    (int_set),
    .byte_valid_o (byte_valid_o),
    .byte_o       (byte_o)
  );

  prn_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_load_i (init_load),
    .busy_clr_i  (busy_clr),
    .int_set_i   (int_set),
    .rd_stat_i   (rd_stat),
    .ctrl_stb_i  (ctrl_q[C_STB]),
    .status_o    (status_q),
    .pend_o      (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= IDLE_BYTE;
    else if (wr_data) data_q <= wdata_i;
  end

  // input latch has no external source here and holds its idle value
  always_comb begin
    unique case (ofs)
      OFS_DATA: rdata_o = ctrl_q[C_DIR] ? IDLE_BYTE : data_q;
      OFS_STAT: rdata_o = status_q;
      OFS_CTRL: rdata_o = ctrl_q;
      default:  rdata_o = IDLE_BYTE;
    endcase
  end

  assign irq_o = pend;
endmodule

// File: rtl/prn_port_regs_chk.sv
module prn_port_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        wdata_i,
  input logic              irq_o,
  input logic              byte_valid_o,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        status_q
);
  a_r1_excl_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i));

  a_r3_ctrl_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[2:0] == 3'd2) |=> (ctrl_q == ($past(wdata_i) | 8'hC0)));

  a_r4_init_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[2:0] == 3'd2 && !wdata_i[2]) |=> (status_q == 8'hD8));

  a_r5_emit_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(wr_i && addr_i[2:0] == 3'd2 &&
                           wdata_i[0] && wdata_i[2] && wdata_i[3]));

  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  a_r7_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wr_i && addr_i[2:0] == 3'd2 && !wdata_i[0]));

  a_r8_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[2:0] == 3'd1) |=> !irq_o);
endmodule

bind prn_port_regs prn_port_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .wdata_i      (wdata_i),
  .irq_o        (irq_o),
  .byte_valid_o (byte_valid_o),
  .ctrl_q       (ctrl_q),
  .status_q     (status_q)
);

// File: tb/prn_port_regs_test.sv
`timescale 1ns/100ps
module prn_port_regs_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, byte_o;
  logic       irq_o, byte_valid_o;

  int checks = 0, errors = 0, bytes_seen = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  prn_port_regs uut (.*);

  always @(posedge clk_i) if (rst_ni && byte_valid_o) bytes_seen++;

  // {rd, addr, wdata, expected, irq after, emit after, req}
  localparam int N = 31;
  localparam logic [30:0] VEC [N] = '{
    {1'b0, 8'h00, 8'h5A, 8'h00, 1'b0, 1'b0, 4'd1},  // R1 data write
    {1'b1, 8'h00, 8'h00, 8'h5A, 1'b0, 1'b0, 4'd10}, // R10 dir=0
    {1'b0, 8'h02, 8'h1D, 8'h5A, 1'b0, 1'b1, 4'd5},  // R5 strobe rise emits
    {1'b1, 8'h02, 8'h00, 8'hDD, 1'b0, 1'b0, 4'd3},  // R3 bits 7:6 forced
    {1'b0, 8'h02, 8'h1C, 8'h00, 1'b1, 1'b0, 4'd7},  // R7 pending set
    {1'b0, 8'h00, 8'h5A, 8'h00, 1'b1, 1'b0, 4'd7},  // R7 irq held on data write
    {1'b1, 8'h01, 8'h00, 8'h59, 1'b0, 1'b0, 4'd8},  // R8 read clears irq
    {1'b1, 8'h01, 8'h00, 8'h19, 1'b0, 1'b0, 4'd9},  // R9 ack cleared
    {1'b1, 8'h01, 8'h00, 8'hD9, 1'b0, 1'b0, 4'd9},  // R9 ack+busy set
    {1'b1, 8'h01, 8'h00, 8'hD9, 1'b0, 1'b0, 4'd9},  // R9 busy: no step
    {1'b0, 8'h02, 8'h1D, 8'h5A, 1'b0, 1'b1, 4'd5},  // R5 second byte
    {1'b0, 8'h02, 8'h1D, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 strobe held: no byte
    {1'b1, 8'h01, 8'h00, 8'h59, 1'b0, 1'b0, 4'd5},  // R5 busy cleared
    {1'b0, 8'h00, 8'h33, 8'h00, 1'b0, 1'b0, 4'd1},
    {1'b0, 8'h02, 8'h15, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 select low
    {1'b0, 8'h02, 8'h14, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 no pending
    {1'b0, 8'h02, 8'h15, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 no byte
    {1'b1, 8'h01, 8'h00, 8'h59, 1'b0, 1'b0, 4'd6},  // R6 status kept
    {1'b0, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 init low
    {1'b1, 8'h01, 8'h00, 8'hD8, 1'b0, 1'b0, 4'd4},  // R4 status loaded
    {1'b1, 8'h00, 8'h00, 8'h33, 1'b0, 1'b0, 4'd10},
    {1'b0, 8'h02, 8'h2C, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 enable was off
    {1'b1, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd10}, // R10 dir=1
    {1'b1, 8'h02, 8'h00, 8'hEC, 1'b0, 1'b0, 4'd3},
    {1'b1, 8'h03, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd1},  // R1 unused offset
    {1'b1, 8'h07, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd1},
    {1'b0, 8'h0B, 8'h00, 8'h00, 1'b0, 1'b0, 4'd1},  // R1 write ignored
    {1'b1, 8'h0A, 8'h00, 8'hEC, 1'b0, 1'b0, 4'd1},  // R1 alias of control
    {1'b0, 8'h08, 8'h77, 8'h00, 1'b0, 1'b0, 4'd1},  // R1 alias of data
    {1'b0, 8'h02, 8'h0C, 8'h00, 1'b0, 1'b0, 4'd3},
    {1'b1, 8'h00, 8'h00, 8'h77, 1'b0, 1'b0, 4'd1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] exp, input logic ei, input logic ee,
                        input string req);
    addr_i = a; wdata_i = d; rd_i = rd; wr_i = !rd;
    #1;
    if (rd) check(req, rdata_o, exp);
    @(posedge clk_i);
    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;
    check(req, {7'd0, irq_o}, {7'd0, ei});
    check(req, {7'd0, byte_valid_o}, {7'd0, ee});
    if (ee) check(req, byte_o, exp);
  endtask

  task automatic reset_reads();
    access(1'b1, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, "R2");
    access(1'b1, 8'h02, 8'h00, 8'hCC, 1'b0, 1'b0, "R2");
    access(1'b1, 8'h01, 8'h00, 8'hD9, 1'b0, 1'b0, "R2");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R2", {6'd0, irq_o, byte_valid_o}, 8'h00);
    rst_ni = 1'b1;
    reset_reads();
    for (int i = 0; i < N; i++)
      access(VEC[i][30], VEC[i][29:22], VEC[i][21:14], VEC[i][13:6],
             VEC[i][5], VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));
    // arm an interrupt, emit one more byte, then reset mid-run
    access(1'b0, 8'h02, 8'h1C, 8'h00, 1'b0, 1'b0, "R7");
    access(1'b0, 8'h02, 8'h1D, 8'h77, 1'b0, 1'b1, "R5");
    access(1'b0, 8'h02, 8'h1C, 8'h00, 1'b1, 1'b0, "R7");
    check("R5", bytes_seen[7:0], 8'd3);
    #1 rst_ni = 1'b0;
    #1 check("R2", {6'd0, irq_o, byte_valid_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    reset_reads();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule